// File: doc/BRIEF.md
# Halt/Stop Standby Mode Controller

This block sits beside a small 8-bit processor core and puts it into one of two standby modes. It watches the opcodes the core retires. A Halt or Stop opcode starts a standby mode only when the opcode retired just before it was a NOP. That NOP empties the pipeline, so the core never stops in the middle of an instruction. In Halt the core clock enable is withheld while peripherals and interrupt logic keep their divided clock. In Stop the oscillator enable is also dropped, which silences every clock.

The block decides how each standby mode ends. An enabled interrupt ends Halt and the core carries on from the instruction after the Halt, with no reset. The reset pin or a watchdog timeout ends Halt with a reset. Stop ignores interrupts. Only the reset pin, a recovery source, or a watchdog timeout can end it, and the watchdog counts only when it is configured to keep running in Stop. Every exit by reset holds the core in reset for a fixed number of oscillator cycles. It then presents the restart address with a one-cycle load strobe.

The block also generates the divided clock enable from a two-bit scaling field. The field may be rewritten at any time, including during Halt. A new ratio takes effect only at the end of the current divided period.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Opcode encodings are NOP = 8'hFF, Halt = 8'h7F and Stop = 8'h6F. When a Halt or Stop opcode retires (op_valid_i high) and the previously retired opcode was a NOP, mode_o shows the new mode in the cycle after the retire edge. Mode encoding: 2'b00 run, 2'b01 halt, 2'b10 stop.
- R2: A Halt or Stop opcode whose previously retired opcode was not a NOP leaves mode_o at run and produces no reset.
- R3: During Halt, cpu_clk_en_o stays low, while periph_clk_en_o keeps pulsing at the selected ratio and osc_en_o stays high.
- R4: During Halt, an interrupt with no reset-pin or watchdog request returns to run in the next cycle. There is no reset and no vector load, and wake_cause_o becomes 2'b00 (interrupt).
- R5: During Halt, the reset pin or a watchdog timeout starts the reset sequence. wake_cause_o becomes 2'b01 for the reset pin and 2'b10 for the watchdog. The reset pin outranks the watchdog, and the watchdog outranks an interrupt in the same cycle.
- R6: During Stop, osc_en_o, periph_clk_en_o and cpu_clk_en_o are all low, and an interrupt has no effect.
- R7: Stop is ended by the reset pin (cause 2'b01), a recovery source (cause 2'b11) or a watchdog timeout (cause 2'b10). The watchdog counts only while wdt_run_in_stop_i is high. Each of these exits starts the reset sequence.
- R8: The reset sequence holds cpu_rst_o high for exactly 16 clock cycles. It then raises vec_load_o for exactly one cycle with vec_addr_o = 16'h000C, and after that the block is in run.
- R9: clk_sel_i selects the peripheral divide ratio: 0 gives /1, 1 gives /2, 2 gives /4, 3 gives /8. A new value takes effect only at the end of the current divided period, including when it is written during Halt. In run, cpu_clk_en_o pulses together with periph_clk_en_o.
- R10: In run, irq_i, rst_pin_i, wdt_timeout_i and rcv_i have no effect on mode, reset or wake cause.
- R11: While rst_ni is low, cpu_rst_o is high, mode_o is run, wake_cause_o is 2'b01, osc_en_o is high and vec_load_o is low. Release of rst_ni starts the reset sequence of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| op_valid_i | input | 1 | Retired-opcode strobe from the core |
| op_i | input | 8 | Opcode retired this cycle |
| irq_i | input | 1 | Enabled interrupt pending |
| rst_pin_i | input | 1 | Synchronized reset-pin request |
| wdt_timeout_i | input | 1 | Watchdog timeout pulse |
| wdt_run_in_stop_i | input | 1 | Watchdog configured to run during Stop |
| rcv_i | input | 1 | Stop recovery source active |
| clk_sel_i | input | 2 | Clock scaling select |
| cpu_clk_en_o | output | 1 | Core clock enable (divided tick, run only) |
| periph_clk_en_o | output | 1 | Peripheral clock enable (divided tick) |
| osc_en_o | output | 1 | Oscillator enable |
| cpu_rst_o | output | 1 | Core reset hold |
| vec_load_o | output | 1 | One-cycle restart vector load strobe |
| vec_addr_o | output | 16 | Restart address, valid with vec_load_o |
| mode_o | output | 2 | Current mode |
| wake_cause_o | output | 2 | Cause of the last wake-up |

## Verification
The wake arbitration and the divider boundary are the places where two functions meet in one cycle. In Halt, an interrupt is raised in the same cycle as a watchdog timeout, and the reset pin together with a watchdog timeout. In Stop, a recovery source is raised together with an interrupt. Each such cycle must produce exactly one outcome with the higher-ranked cause, which a scoreboard of expected mode and cause events judges. A scale change written one cycle after a tick must leave the running /8 period intact, so the gap to the next tick is measured.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int unsigned OP_W = 8;
  localparam logic [OP_W-1:0] OP_NOP  = 8'hFF;
  localparam logic [OP_W-1:0] OP_HALT = 8'h7F;
  localparam logic [OP_W-1:0] OP_STOP = 8'h6F;

  typedef enum logic [2:0] {ST_RUN, ST_HALT, ST_STOP, ST_HOLD, ST_VEC} pm_state_e;
  typedef enum logic [1:0] {MODE_RUN = 2'b00, MODE_HALT = 2'b01, MODE_STOP = 2'b10} mode_e;
  typedef enum logic [1:0] {WAKE_IRQ = 2'b00, WAKE_PIN = 2'b01, WAKE_WDT = 2'b10, WAKE_RCV = 2'b11} wake_e;
endpackage

// File: rtl/pwr_op_detect.sv
module pwr_op_detect
  import pwr_mode_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arm_i,
  input  logic            op_valid_i,
  input  logic [OP_W-1:0] op_i,
  output logic            halt_req_o,
  output logic            stop_req_o
);
  logic prev_nop_q;

  // remembers whether the last retired opcode flushed the pipeline
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         prev_nop_q <= 1'b0;
    else if (!arm_i)     prev_nop_q <= 1'b0;
    else if (op_valid_i) prev_nop_q <= (op_i == OP_NOP);
  end

  always_comb begin
    halt_req_o = arm_i && op_valid_i && prev_nop_q && (op_i == OP_HALT);
    stop_req_o = arm_i && op_valid_i && prev_nop_q && (op_i == OP_STOP);
  end

  assert_one_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(halt_req_o && stop_req_o));
endmodule

// File: rtl/pwr_clk_div.sv
module pwr_clk_div #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   ratio;
  logic [CNT_W-1:0] lim;

  always_comb begin
    ratio  = (CNT_W+1)'(1) << sel_q;
    lim    = CNT_W'(ratio - 1'b1);
    tick_o = run_i && (cnt_q == lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sel_q <= sel_i;
    end else if (tick_o) begin
      cnt_q <= '0;
      sel_q <= sel_i;            // new ratio only at period end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_sel_at_boundary_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && run_i && !$past(tick_o)) |-> $stable(sel_q));
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      halt_req_i,
  input  logic      stop_req_i,
  input  logic      irq_i,
  input  logic      rst_pin_i,
  input  logic      wdt_timeout_i,
  input  logic      wdt_run_in_stop_i,
  input  logic      rcv_i,
  output pm_state_e state_o,
  output wake_e     cause_o
);
  localparam int unsigned CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam int unsigned LEN_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(RST_CYCLES - 1);
  localparam logic [LEN_W-1:0] LEN_MAX   = LEN_W'(RST_CYCLES);

  pm_state_e        state_q, state_d;
  wake_e            cause_q, cause_d;
  logic [CNT_W-1:0] hold_cnt_q;

  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    unique case (state_q)
      ST_RUN: begin
        if (halt_req_i)      state_d = ST_HALT;
        else if (stop_req_i) state_d = ST_STOP;
      end
      ST_HALT: begin
        if (rst_pin_i)          begin state_d = ST_HOLD; cause_d = WAKE_PIN; end
        else if (wdt_timeout_i) begin state_d = ST_HOLD; cause_d = WAKE_WDT; end
        else if (irq_i)         begin state_d = ST_RUN;  cause_d = WAKE_IRQ; end
      end
      ST_STOP: begin
        if (rst_pin_i)                               begin state_d = ST_HOLD; cause_d = WAKE_PIN; end
        else if (wdt_timeout_i && wdt_run_in_stop_i) begin state_d = ST_HOLD; cause_d = WAKE_WDT; end
        else if (rcv_i)                              begin state_d = ST_HOLD; cause_d = WAKE_RCV; end
      end
      ST_HOLD: if (hold_cnt_q == HOLD_LAST) state_d = ST_VEC;
      ST_VEC:  state_d = ST_RUN;
      default: state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HOLD;
      cause_q    <= WAKE_PIN;
      hold_cnt_q <= '0;
    end else begin
      state_q    <= state_d;
      cause_q    <= cause_d;
      hold_cnt_q <= (state_q == ST_HOLD) ? hold_cnt_q + 1'b1 : '0;
    end
  end

  assign state_o = state_q;
  assign cause_o = cause_q;

  // independent length counter for the reset hold window
  logic [LEN_W-1:0] rst_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rst_len_q <= '0;
    else if (state_q == ST_HOLD) rst_len_q <= (rst_len_q == LEN_MAX) ? rst_len_q : rst_len_q + 1'b1;
    else                        rst_len_q <= '0;
  end

  assert_hold_length_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(state_q == ST_HOLD) |-> (rst_len_q == LEN_MAX));
  assert_halt_irq_resume_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT && irq_i && !rst_pin_i && !wdt_timeout_i) |=> (state_q == ST_RUN && cause_q == WAKE_IRQ));
  assert_stop_ignores_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && !rst_pin_i && !rcv_i && !(wdt_timeout_i && wdt_run_in_stop_i)) |=> state_q == ST_STOP);
  assert_run_ignores_wake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !halt_req_i && !stop_req_i) |=> (state_q == ST_RUN && $stable(cause_q)));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned RST_CYCLES = 16,
  parameter int unsigned VEC_W      = 16,
  parameter logic [VEC_W-1:0] RESTART_VEC = 'h000C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic             irq_i,
  input  logic             rst_pin_i,
  input  logic             wdt_timeout_i,
  input  logic             wdt_run_in_stop_i,
  input  logic             rcv_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  output logic             cpu_clk_en_o,
  output logic             periph_clk_en_o,
  output logic             osc_en_o,
  output logic             cpu_rst_o,
  output logic             vec_load_o,
  output logic [VEC_W-1:0] vec_addr_o,
  output logic [1:0]       mode_o,
  output logic [1:0]       wake_cause_o
);
  pm_state_e state;
  wake_e     cause;
  logic      halt_req, stop_req, tick;

  pwr_op_detect u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (state == ST_RUN),
    .op_valid_i (op_valid_i),
    .op_i       (op_i),
    .halt_req_o (halt_req),
    .stop_req_o (stop_req)
  );

  pwr_mode_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .halt_req_i        (halt_req),
    .stop_req_i        (stop_req),
    .irq_i             (irq_i),
    .rst_pin_i         (rst_pin_i),
    .wdt_timeout_i     (wdt_timeout_i),
    .wdt_run_in_stop_i (wdt_run_in_stop_i),
    .rcv_i             (rcv_i),
    .state_o           (state),
    .cause_o           (cause)
  );

  pwr_clk_div #(.SEL_W(SEL_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (osc_en_o),
    .sel_i  (clk_sel_i),
    .tick_o (tick)
  );

  always_comb begin
    osc_en_o        = (state != ST_STOP);
    periph_clk_en_o = tick;
    cpu_clk_en_o    = tick && (state == ST_RUN);
    cpu_rst_o       = (state == ST_HOLD);
    vec_load_o      = (state == ST_VEC);
    vec_addr_o      = vec_load_o ? RESTART_VEC : '0;
    wake_cause_o    = cause;
    unique case (state)
      ST_HALT: mode_o = MODE_HALT;
      ST_STOP: mode_o = MODE_STOP;
      default: mode_o = MODE_RUN;
    endcase
  end

  assert_cpu_clk_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |-> (periph_clk_en_o && mode_o == MODE_RUN));
  assert_stop_dark_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_STOP) |-> (!osc_en_o && !periph_clk_en_o && !cpu_clk_en_o));
  assert_vec_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_load_o |=> (!vec_load_o && !cpu_rst_o && mode_o == MODE_RUN));
  assert_rst_then_vec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_rst_o) |-> (vec_load_o && vec_addr_o == RESTART_VEC));
endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [7:0] op = 8'h00;
  logic       irq = 1'b0, pin = 1'b0, wdt = 1'b0, wdt_run = 1'b0, rcv = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       cpu_en, per_en, osc_en, cpu_rst, vec_load;
  logic [15:0] vec_addr;
  logic [1:0] mode, cause;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_mode_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op),
    .irq_i(irq), .rst_pin_i(pin), .wdt_timeout_i(wdt), .wdt_run_in_stop_i(wdt_run),
    .rcv_i(rcv), .clk_sel_i(sel),
    .cpu_clk_en_o(cpu_en), .periph_clk_en_o(per_en), .osc_en_o(osc_en),
    .cpu_rst_o(cpu_rst), .vec_load_o(vec_load), .vec_addr_o(vec_addr),
    .mode_o(mode), .wake_cause_o(cause)
  );

  typedef struct {
    string      req;
    logic [1:0] mode;
    logic [1:0] cause;
    logic       vec;
  } exp_t;
  exp_t sb_q[$];
  exp_t got;
  logic [3:0] prev_obs = 4'b0001;

  task automatic push(input string req, input logic [1:0] m, input logic [1:0] c, input logic v);
    exp_t e;
    e.req = req; e.mode = m; e.cause = c; e.vec = v;
    sb_q.push_back(e);
  endtask

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: every change of mode/cause and every vector load is one event
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (vec_load || {mode, cause} != prev_obs) begin
        compared++;
        if (sb_q.size() == 0) begin
          mismatched++;
          $display("FAIL scoreboard R1: unexpected event actual mode=%0d cause=%0d vec=%0b expected none",
                   mode, cause, vec_load);
        end else begin
          got = sb_q.pop_front();
          if (mode != got.mode || cause != got.cause || vec_load != got.vec ||
              (got.vec && vec_addr != 16'h000C)) begin
            mismatched++;
            $display("FAIL %s: actual mode=%0d cause=%0d vec=%0b addr=%h expected mode=%0d cause=%0d vec=%0b addr=000c",
                     got.req, mode, cause, vec_load, vec_addr, got.mode, got.cause, got.vec);
          end
        end
      end
      prev_obs = {mode, cause};
    end
  end

  task automatic retire(input logic [7:0] code);
    @(negedge clk); op_valid = 1'b1; op = code;
    @(negedge clk); op_valid = 1'b0; op = 8'h00;
  endtask

  task automatic pulse(input logic p_irq, input logic p_pin, input logic p_wdt, input logic p_rcv);
    @(negedge clk); irq = p_irq; pin = p_pin; wdt = p_wdt; rcv = p_rcv;
    @(negedge clk); irq = 1'b0; pin = 1'b0; wdt = 1'b0; rcv = 1'b0;
  endtask

  task automatic count_ticks(input int n, output int p, output int c);
    p = 0; c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      p += int'(per_en);
      c += int'(cpu_en);
    end
  endtask

  task automatic measure_reset(input string req);
    int n = 0;
    while (cpu_rst && n < 64) begin
      n++;
      @(negedge clk);
    end
    check({req, " R8 hold length"}, n, 16);
    check({req, " R8 vec strobe"}, int'(vec_load), 1);
    check({req, " R8 vec addr"}, int'(vec_addr), 16'h000C);
    @(negedge clk);
    check({req, " R8 single strobe"}, int'(vec_load), 0);
    check({req, " R8 back in run"}, int'({cpu_rst, mode}), 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog R8: actual hung expected completion");
    finish_run();
  end

  initial begin
    int p, c, n;
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 cpu_rst", int'(cpu_rst), 1);
    check("R11 mode", int'(mode), 0);
    check("R11 cause", int'(cause), 1);
    check("R11 osc", int'(osc_en), 1);
    check("R11 vec", int'(vec_load), 0);
    push("R11 por vector", 2'b00, 2'b01, 1'b1);
    rst_n = 1'b1;
    measure_reset("R11");

    // R9 divide-by-1
    count_ticks(32, p, c);
    check("R9 div1 periph", p, 32);
    check("R9 div1 cpu", c, 32);

    // R2 entry without NOP
    retire(8'h00); retire(8'h7F);
    check("R2 halt w/o nop", int'(mode), 0);
    retire(8'h6F);
    check("R2 stop after halt op", int'(mode), 0);
    check("R2 no reset", int'(cpu_rst), 0);

    // R1/R3 halt entry
    push("R1 halt entry", 2'b01, 2'b01, 1'b0);
    retire(8'hFF); retire(8'h7F);
    check("R1 mode halt", int'(mode), 1);
    count_ticks(32, p, c);
    check("R3 periph in halt", p, 32);
    check("R3 cpu gated", c, 0);
    check("R3 osc on", int'(osc_en), 1);
    // R9 scale change while halted
    sel = 2'd2;
    repeat (16) @(negedge clk);
    count_ticks(32, p, c);
    check("R9 div4 in halt", p, 8);

    // R4 interrupt resume
    push("R4 irq resume", 2'b00, 2'b00, 1'b0);
    pulse(1, 0, 0, 0);
    check("R4 no reset", int'(cpu_rst), 0);
    check("R4 no vec", int'(vec_load), 0);
    count_ticks(32, p, c);
    check("R9 cpu div4 in run", c, 8);

    // R5 collision: irq with watchdog
    push("R1 halt entry 2", 2'b01, 2'b00, 1'b0);
    retire(8'hFF); retire(8'h7F);
    push("R5 wdt over irq", 2'b00, 2'b10, 1'b0);
    push("R5 wdt vector", 2'b00, 2'b10, 1'b1);
    pulse(1, 0, 1, 0);
    measure_reset("R5 wdt");

    // R5 reset pin over watchdog
    push("R1 halt entry 3", 2'b01, 2'b10, 1'b0);
    retire(8'hFF); retire(8'h7F);
    push("R5 pin over wdt", 2'b00, 2'b01, 1'b0);
    push("R5 pin vector", 2'b00, 2'b01, 1'b1);
    pulse(0, 1, 1, 0);
    measure_reset("R5 pin");

    // R10 wake inputs in run
    pulse(1, 0, 0, 0); pulse(0, 1, 0, 0); pulse(0, 0, 1, 0); pulse(0, 0, 0, 1);
    check("R10 mode run", int'(mode), 0);
    check("R10 no reset", int'(cpu_rst), 0);
    check("R10 cause kept", int'(cause), 1);

    // R6 stop entry
    push("R6 stop entry", 2'b10, 2'b01, 1'b0);
    retire(8'hFF); retire(8'h6F);
    check("R6 osc off", int'(osc_en), 0);
    count_ticks(16, p, c);
    check("R6 periph off", p, 0);
    check("R6 cpu off", c, 0);
    pulse(1, 0, 0, 0);
    check("R6 irq ignored", int'(mode), 2);
    pulse(0, 0, 1, 0);
    check("R7 wdt not running", int'(mode), 2);

    // R7 recovery with irq
    push("R7 rcv exit", 2'b00, 2'b11, 1'b0);
    push("R7 rcv vector", 2'b00, 2'b11, 1'b1);
    pulse(1, 0, 0, 1);
    check("R7 osc back", int'(osc_en), 1);
    measure_reset("R7 rcv");

    // R7 watchdog running in stop
    push("R6 stop entry 2", 2'b10, 2'b11, 1'b0);
    retire(8'hFF); retire(8'h6F);
    wdt_run = 1'b1;
    push("R7 wdt exit", 2'b00, 2'b10, 1'b0);
    push("R7 wdt vector", 2'b00, 2'b10, 1'b1);
    pulse(0, 0, 1, 0);
    measure_reset("R7 wdt");
    wdt_run = 1'b0;

    // R7 reset pin in stop
    push("R6 stop entry 3", 2'b10, 2'b10, 1'b0);
    retire(8'hFF); retire(8'h6F);
    push("R7 pin exit", 2'b00, 2'b01, 1'b0);
    push("R7 pin vector", 2'b00, 2'b01, 1'b1);
    pulse(0, 1, 0, 0);
    measure_reset("R7 pin");

    // R1 NOP NOP HALT
    push("R1 halt after two nops", 2'b01, 2'b01, 1'b0);
    retire(8'hFF); retire(8'hFF); retire(8'h7F);
    check("R1 double nop halt", int'(mode), 1);
    push("R4 irq resume 2", 2'b00, 2'b00, 1'b0);
    pulse(1, 0, 0, 0);

    // R9 change lands only at period end
    sel = 2'd3;
    repeat (40) @(negedge clk);
    n = 0;
    while (!per_en && n < 64) begin @(negedge clk); n++; end
    @(negedge clk); sel = 2'd0;
    n = 1;
    while (!per_en && n < 64) begin @(negedge clk); n++; end
    check("R9 old period kept", n, 8);
    @(negedge clk);
    check("R9 div1 after boundary", int'(per_en), 1);

    repeat (2) @(negedge clk);
    check("R1 scoreboard drained", sb_q.size(), 0);
    finish_run();
  end
endmodule